// File: doc/BRIEF.md
# Serial Link Controller Power-Mode Unit

This unit decides when a byte-oriented serial link controller runs, waits or stops. The CPU sends power requests. A control bit chooses whether a wait request gives a light sleep or a full stop. In the light sleep (wait) the internal clocks keep running, so a frame that is already arriving is still received. The transmitter is kept off the bus. A good received frame returns the unit to run and can raise an interrupt. In the deep sleep (stop) the clock-gate enable is low. Only an external wake input returns the unit to run.

The unit also carries out a transmit abort. It lets the byte in flight finish, then drives logic 1 for a fixed number of bit times (two by default), then signals that the transmitter has halted. Because those trailing ones do not fill a whole byte, a receiver that sees them reports an invalid symbol, and the unit forwards that report. Power requests that arrive while a transmission or an abort is in progress wait until it ends.

Every pin is a plain control or status strobe. No data stream passes through the unit, so it has no valid/ready handshake and applies no back-pressure.

Top module: `slc_pwr_ctrl`

## Requirements
- R1: While `rst` is sampled high, the outputs after the edge are: `mode`=2'b00 (run), `irq`=0, `abort_active`=0, `force_ones`=0, `tx_halt`=0, `wakeup`=0, `clk_en`=1 and `tx_inhibit`=0.
- R2: In run, `wait_req` with `wcm`=0 gives `mode`=2'b01 (wait) one cycle later. In wait, `clk_en`=1 and `tx_inhibit`=1.
- R3: In run, `stop_req`, or `wait_req` with `wcm`=1, gives `mode`=2'b10 (stop) one cycle later. In stop, `clk_en`=0 and `tx_inhibit`=1.
- R4: A request that arrives while `tx_busy`=1 or `abort_active`=1 is held pending. The mode does not change until the first edge at which both are low. The mode then changes one cycle after that edge.
- R5: In wait, `rx_msg_ok` gives `mode`=run one cycle later. In that same cycle `wakeup` is high for exactly one cycle.
- R6: A wake from wait sets `irq` one cycle after `rx_msg_ok` if `irq_en`=1, and leaves it clear if `irq_en`=0. `irq` stays high until `irq_ack` is sampled. It is low in the cycle after that.
- R7: In stop, `rx_msg_ok` has no effect. `ext_wake` gives `mode`=run and a one-cycle `wakeup` one cycle later.
- R8: `wait_req` and `stop_req` are ignored while the mode is wait or stop.
- R9: `abort_req` with `tx_busy`=1 in run sets `abort_active` one cycle later. After the next `byte_done`, `force_ones` is high, starting the cycle after. It drops one cycle after the TRAIL_BITS-th `bit_tick` (default 2). In that same cycle `abort_active` clears and `tx_halt` is high for one cycle.
- R10: `abort_req` is ignored when `tx_busy`=0 or when the mode is not run.
- R11: `rx_trail_ones` makes `rx_invalid_sym` high for one cycle, one cycle later, in run or wait. In stop it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wait_req | input | 1 | CPU wait request strobe |
| stop_req | input | 1 | CPU stop request strobe |
| wcm | input | 1 | Wait-clock-mode bit: 1 turns wait into stop |
| irq_en | input | 1 | Interrupt enable |
| rx_msg_ok | input | 1 | Received frame completed without error |
| rx_trail_ones | input | 1 | Receiver saw trailing ones off a byte boundary |
| tx_busy | input | 1 | Transmitter is sending |
| abort_req | input | 1 | Transmit abort request strobe |
| byte_done | input | 1 | Transmitter byte boundary strobe |
| bit_tick | input | 1 | One bit time elapsed strobe |
| ext_wake | input | 1 | External wake from stop |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| mode | output | 2 | 00 run, 01 wait, 10 stop |
| tx_inhibit | output | 1 | Transmitter must not drive the bus |
| clk_en | output | 1 | Clock-gate enable |
| wakeup | output | 1 | One-cycle wake pulse |
| irq | output | 1 | Interrupt request |
| abort_active | output | 1 | Abort sequence in progress |
| force_ones | output | 1 | Transmitter drives logic 1 |
| tx_halt | output | 1 | One-cycle pulse: abort complete |
| rx_invalid_sym | output | 1 | Invalid-symbol report pulse |

## Verification
Every registered result is due exactly one clock edge after the input that causes it is sampled. The exceptions are held requests: they resolve on the edge after `tx_busy` and `abort_active` both fall, so the mode change after an abort comes two edges after the final `bit_tick`. The bench drives inputs just after a rising edge. It enqueues each expected value tagged with the absolute cycle at which it is due. The monitor compares it on the falling edge of exactly that cycle. A stale entry counts as a failure.

// File: rtl/slc_pwr_pkg.sv
package slc_pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'b00,
    PM_WAIT = 2'b01,
    PM_STOP = 2'b10
  } pm_mode_e;

  typedef enum logic [1:0] {
    AB_IDLE   = 2'b00,
    AB_FINISH = 2'b01,
    AB_ONES   = 2'b10
  } ab_state_e;
endpackage

// File: rtl/slc_mode_fsm.sv
module slc_mode_fsm
  import slc_pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wait_req,
  input  logic     stop_req,
  input  logic     wcm,
  input  logic     rx_msg_ok,
  input  logic     ext_wake,
  input  logic     hold,
  output pm_mode_e mode_o,
  output logic     wake_o,
  output logic     wait_wake_o
);
  pm_mode_e mode_q, mode_d;
  logic pend_q, pend_d, pend_stop_q, pend_stop_d, wake_d, wake_q;
  logic req_now, req_stop, eff_pend, eff_stop;

  // Requests are only accepted in run; stop dominates a pending wait.
  assign req_now  = (mode_q == PM_RUN) && (wait_req || stop_req);
  assign req_stop = stop_req || (wait_req && wcm);
  assign eff_pend = pend_q || req_now;
  assign eff_stop = pend_stop_q || (req_now && req_stop);

  always_comb begin
    mode_d      = mode_q;
    pend_d      = pend_q;
    pend_stop_d = pend_stop_q;
    wake_d      = 1'b0;
    unique case (mode_q)
      PM_RUN: begin
        if (eff_pend && !hold) begin
          mode_d      = eff_stop ? PM_STOP : PM_WAIT;
          pend_d      = 1'b0;
          pend_stop_d = 1'b0;
        end else if (req_now) begin
          pend_d      = 1'b1;
          pend_stop_d = eff_stop;
        end
      end
      PM_WAIT: begin
        if (rx_msg_ok) begin
          mode_d = PM_RUN;
          wake_d = 1'b1;
        end
      end
      PM_STOP: begin
        if (ext_wake) begin
          mode_d = PM_RUN;
          wake_d = 1'b1;
        end
      end
      default: mode_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= PM_RUN;
      pend_q      <= 1'b0;
      pend_stop_q <= 1'b0;
      wake_q      <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      pend_q      <= pend_d;
      pend_stop_q <= pend_stop_d;
      wake_q      <= wake_d;
    end
  end

  assign mode_o      = mode_q;
  assign wake_o      = wake_q;
  assign wait_wake_o = (mode_q == PM_WAIT) && rx_msg_ok;
endmodule

// File: rtl/slc_abort_seq.sv
module slc_abort_seq
  import slc_pwr_pkg::*;
#(
  parameter int TRAIL_BITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic byte_done,
  input  logic bit_tick,
  output logic active_o,
  output logic force_o,
  output logic halt_o
);
  localparam int CW = (TRAIL_BITS > 1) ? $clog2(TRAIL_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TRAIL_BITS - 1);

  ab_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic halt_d, halt_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    halt_d = 1'b0;
    unique case (st_q)
      AB_IDLE: if (start) begin
        st_d  = AB_FINISH;
        cnt_d = '0;
      end
      AB_FINISH: if (byte_done) st_d = AB_ONES;
      AB_ONES: if (bit_tick) begin
        if (cnt_q == LAST) begin
          st_d   = AB_IDLE;
          halt_d = 1'b1;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = AB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= AB_IDLE;
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      halt_q <= halt_d;
    end
  end

  assign active_o = (st_q != AB_IDLE);
  assign force_o  = (st_q == AB_ONES);
  assign halt_o   = halt_q;
endmodule

// File: rtl/slc_irq_latch.sv
module slc_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic enable,
  input  logic ack,
  output logic irq_o
);
  logic irq_q;

  // A new set wins over an acknowledge in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                    irq_q <= 1'b0;
    else if (set_evt && enable) irq_q <= 1'b1;
    else if (ack)               irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/slc_pwr_ctrl.sv
module slc_pwr_ctrl
  import slc_pwr_pkg::*;
#(
  parameter int TRAIL_BITS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wait_req,
  input  logic       stop_req,
  input  logic       wcm,
  input  logic       irq_en,
  input  logic       rx_msg_ok,
  input  logic       rx_trail_ones,
  input  logic       tx_busy,
  input  logic       abort_req,
  input  logic       byte_done,
  input  logic       bit_tick,
  input  logic       ext_wake,
  input  logic       irq_ack,
  output logic [1:0] mode,
  output logic       tx_inhibit,
  output logic       clk_en,
  output logic       wakeup,
  output logic       irq,
  output logic       abort_active,
  output logic       force_ones,
  output logic       tx_halt,
  output logic       rx_invalid_sym
);
  pm_mode_e cur_mode;
  logic     wait_wake, hold, ab_start, sym_q;

  assign hold     = tx_busy || abort_active;
  assign ab_start = abort_req && tx_busy && (cur_mode == PM_RUN);

  slc_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .wait_req    (wait_req),
    .stop_req    (stop_req),
    .wcm         (wcm),
    .rx_msg_ok   (rx_msg_ok),
    .ext_wake    (ext_wake),
    .hold        (hold),
    .mode_o      (cur_mode),
    .wake_o      (wakeup),
    .wait_wake_o (wait_wake)
  );

  slc_abort_seq #(.TRAIL_BITS(TRAIL_BITS)) u_abort (
    .clk       (clk),
    .rst       (rst),
    .start     (ab_start),
    .byte_done (byte_done),
    .bit_tick  (bit_tick),
    .active_o  (abort_active),
    .force_o   (force_ones),
    .halt_o    (tx_halt)
  );

  slc_irq_latch u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_evt (wait_wake),
    .enable  (irq_en),
    .ack     (irq_ack),
    .irq_o   (irq)
  );

  // Receive-side fault report, frozen while clocks are gated.
  always_ff @(posedge clk) begin
    if (rst) sym_q <= 1'b0;
    else     sym_q <= rx_trail_ones && (cur_mode != PM_STOP);
  end

  assign rx_invalid_sym = sym_q;
  assign mode           = cur_mode;
  assign tx_inhibit     = (cur_mode != PM_RUN);
  assign clk_en         = (cur_mode != PM_STOP);
endmodule

// File: rtl/slc_pwr_ctrl_chk.sv
module slc_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_msg_ok,
  input logic       rx_trail_ones,
  input logic       tx_busy,
  input logic       ext_wake,
  input logic       irq_ack,
  input logic [1:0] mode,
  input logic       tx_inhibit,
  input logic       wakeup,
  input logic       irq,
  input logic       abort_active,
  input logic       force_ones,
  input logic       tx_halt,
  input logic       rx_invalid_sym
);
  // R4
  hold_run_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_busy || abort_active) && mode == 2'b00) |=> mode == 2'b00);
  // R5
  wait_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && rx_msg_ok) |=> (mode == 2'b00 && wakeup));
  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && irq_ack && !(mode == 2'b01 && rx_msg_ok)) |=> !irq);
  // R7
  stop_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !ext_wake) |=> mode == 2'b10);
  // R9
  halt_after_ones_chk: assert property (@(posedge clk) disable iff (rst)
    tx_halt |-> $past(force_ones));
  // R2
  ones_only_run_chk: assert property (@(posedge clk) disable iff (rst)
    force_ones |-> !tx_inhibit);
  // R11
  sym_report_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_trail_ones && mode != 2'b10) |=> rx_invalid_sym);
endmodule

bind slc_pwr_ctrl slc_pwr_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .rx_msg_ok      (rx_msg_ok),
  .rx_trail_ones  (rx_trail_ones),
  .tx_busy        (tx_busy),
  .ext_wake       (ext_wake),
  .irq_ack        (irq_ack),
  .mode           (mode),
  .tx_inhibit     (tx_inhibit),
  .wakeup         (wakeup),
  .irq            (irq),
  .abort_active   (abort_active),
  .force_ones     (force_ones),
  .tx_halt        (tx_halt),
  .rx_invalid_sym (rx_invalid_sym)
);

// File: tb/slc_pwr_ctrl_test.sv
module slc_pwr_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wait_req = 0, stop_req = 0, wcm = 0, irq_en = 0, rx_msg_ok = 0;
  logic rx_trail_ones = 0, tx_busy = 0, abort_req = 0, byte_done = 0;
  logic bit_tick = 0, ext_wake = 0, irq_ack = 0;
  logic [1:0] mode;
  logic tx_inhibit, clk_en, wakeup, irq, abort_active, force_ones, tx_halt, rx_invalid_sym;

  always #10 clk = ~clk;

  slc_pwr_ctrl uut (
    .clk(clk), .rst(rst), .wait_req(wait_req), .stop_req(stop_req), .wcm(wcm),
    .irq_en(irq_en), .rx_msg_ok(rx_msg_ok), .rx_trail_ones(rx_trail_ones),
    .tx_busy(tx_busy), .abort_req(abort_req), .byte_done(byte_done),
    .bit_tick(bit_tick), .ext_wake(ext_wake), .irq_ack(irq_ack), .mode(mode),
    .tx_inhibit(tx_inhibit), .clk_en(clk_en), .wakeup(wakeup), .irq(irq),
    .abort_active(abort_active), .force_ones(force_ones), .tx_halt(tx_halt),
    .rx_invalid_sym(rx_invalid_sym)
  );

  localparam logic [9:0] M_MODE = 10'h300, TXI = 10'h080, CKE = 10'h040,
                         WAK = 10'h020, IRQ = 10'h010, ABA = 10'h008,
                         FRC = 10'h004, HLT = 10'h002, SYM = 10'h001;
  localparam logic [9:0] RUN = 10'h000, WAITM = 10'h100, STOPM = 10'h200;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;
  int         q_cyc[$];
  logic [9:0] q_mask[$];
  logic [9:0] q_val[$];
  string      q_tag[$];

  wire [9:0] obs = {mode, tx_inhibit, clk_en, wakeup, irq, abort_active,
                    force_ones, tx_halt, rx_invalid_sym};

  always @(posedge clk) cyc <= cyc + 1;

  // Driver side: queue an expectation due dly edges after now.
  task automatic expect_obs(int dly, logic [9:0] m, logic [9:0] v, string tag);
    q_cyc.push_back(cyc + dly);
    q_mask.push_back(m);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: compare on the falling edge of the cycle each item is due.
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      checks++;
      if (q_cyc[0] < cyc) begin
        errors++;
        $display("FAIL %s stale: actual=%h expected=%h", q_tag[0], obs & q_mask[0], q_val[0]);
      end else if ((obs & q_mask[0]) !== q_val[0]) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", q_tag[0], obs & q_mask[0], q_val[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_mask.pop_front());
      void'(q_val.pop_front());
      void'(q_tag.pop_front());
    end
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    expect_obs(1, M_MODE|TXI|CKE|WAK|IRQ|ABA|FRC|HLT|SYM, RUN|CKE, "R1 reset");
    tick();
    rst = 0;
    tick();

    // R2 wait entry
    wcm = 0; wait_req = 1;
    expect_obs(1, M_MODE|TXI|CKE, WAITM|TXI|CKE, "R2 wait entry");
    tick(); wait_req = 0;
    // R8 request ignored in wait
    stop_req = 1;
    expect_obs(1, M_MODE, WAITM, "R8 stop_req ignored in wait");
    tick(); stop_req = 0;
    // R11 report in wait
    rx_trail_ones = 1;
    expect_obs(1, SYM, SYM, "R11 invalid symbol in wait");
    tick(); rx_trail_ones = 0;
    expect_obs(1, SYM, 10'h000, "R11 pulse length");
    // R5 R6 wake with interrupt
    irq_en = 1; rx_msg_ok = 1;
    expect_obs(1, M_MODE|WAK|IRQ, RUN|WAK|IRQ, "R5 R6 wake with irq");
    tick(); rx_msg_ok = 0;
    expect_obs(1, WAK|IRQ, IRQ, "R5 wake pulse one cycle / R6 irq held");
    tick(); tick();
    expect_obs(1, IRQ, IRQ, "R6 irq held before ack");
    tick();
    irq_ack = 1;
    expect_obs(1, IRQ, 10'h000, "R6 irq cleared by ack");
    tick(); irq_ack = 0;

    // R6 wake with interrupt disabled
    wait_req = 1;
    tick(); wait_req = 0; irq_en = 0; rx_msg_ok = 1;
    expect_obs(1, M_MODE|WAK|IRQ, RUN|WAK, "R6 no irq when disabled");
    tick(); rx_msg_ok = 0;

    // R3 stop entry and R7
    stop_req = 1;
    expect_obs(1, M_MODE|TXI|CKE, STOPM|TXI, "R3 stop entry");
    tick(); stop_req = 0;
    rx_msg_ok = 1;
    expect_obs(1, M_MODE|WAK, STOPM, "R7 rx_msg_ok ignored in stop");
    tick(); rx_msg_ok = 0;
    wait_req = 1;
    expect_obs(1, M_MODE, STOPM, "R8 wait_req ignored in stop");
    tick(); wait_req = 0;
    rx_trail_ones = 1;
    expect_obs(1, SYM, 10'h000, "R11 ignored in stop");
    tick(); rx_trail_ones = 0;
    ext_wake = 1;
    expect_obs(1, M_MODE|WAK|CKE, RUN|WAK|CKE, "R7 external wake");
    tick(); ext_wake = 0;

    // R3 wait with wcm set
    wcm = 1; wait_req = 1;
    expect_obs(1, M_MODE|CKE, STOPM, "R3 wait with wcm gives stop");
    tick(); wait_req = 0; wcm = 0;
    ext_wake = 1;
    tick(); ext_wake = 0;

    // R4 held by tx_busy
    tx_busy = 1; wait_req = 1;
    expect_obs(1, M_MODE, RUN, "R4 held while busy");
    tick(); wait_req = 0;
    tick();
    expect_obs(1, M_MODE, RUN, "R4 still held");
    tick();
    tx_busy = 0;
    expect_obs(1, M_MODE|TXI, WAITM|TXI, "R4 released after busy");
    tick();
    rx_msg_ok = 1;
    tick(); rx_msg_ok = 0;

    // R9 abort with pending wait (R4)
    tx_busy = 1; abort_req = 1; wait_req = 1;
    expect_obs(1, M_MODE|ABA|FRC, RUN|ABA, "R9 abort started");
    tick(); abort_req = 0; wait_req = 0;
    bit_tick = 1;
    expect_obs(1, FRC|ABA, ABA, "R9 ticks ignored before byte end");
    tick(); bit_tick = 0;
    byte_done = 1;
    expect_obs(1, M_MODE|FRC, RUN|FRC, "R9 ones after byte");
    tick(); byte_done = 0; tx_busy = 0;
    bit_tick = 1;
    expect_obs(1, FRC|HLT, FRC, "R9 first trailing bit");
    tick(); bit_tick = 0;
    expect_obs(1, M_MODE|FRC, RUN|FRC, "R4 held during abort");
    tick();
    bit_tick = 1;
    expect_obs(1, M_MODE|FRC|HLT|ABA, RUN|HLT, "R9 halt after two ones");
    expect_obs(2, M_MODE|HLT, WAITM, "R4 pending wait taken after abort");
    tick(); bit_tick = 0;
    tick();
    rx_msg_ok = 1;
    tick(); rx_msg_ok = 0;

    // R10 abort ignored when not busy
    abort_req = 1;
    expect_obs(1, ABA|FRC, 10'h000, "R10 abort ignored when idle");
    tick(); abort_req = 0;
    // R11 in run
    rx_trail_ones = 1;
    expect_obs(1, SYM, SYM, "R11 invalid symbol in run");
    tick(); rx_trail_ones = 0;

    tick(); tick(); tick();
    summary();
  end
endmodule